// File: doc/BRIEF.md
# I2C Sub-Address Register Slave

This block is the serial front end of a small peripheral. It runs on a fast system clock and oversamples the two-wire bus lines, SCL and SDA. Each line passes through a two-flop synchronizer and a short glitch filter. The block recognises START and STOP, answers to one 7-bit device address, and turns bus traffic into simple register-side strobes.

A write transfer works as follows. The first byte after the address sets a 3-bit register pointer. Every later byte produces a one-cycle write strobe at that pointer, and the pointer then moves up by one. A read transfer needs no pointer phase: the block samples a status byte, raises a read strobe, and shifts the byte out.

The bus side only pulls SDA low or releases it. The surrounding pad logic turns `sda_oe` into an open-drain driver.

Top module: `i2c_subaddr_slave`

## Requirements
- R1: The device address is binary 0100 followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]`, and is received MSB first. A matching address is acknowledged.
- R2: A non-matching address gets no ACK. Later bytes get no ACK and cause no write, up to the next START.
- R3: R/W (the 8th bit after the address) = 0 selects a write. The next byte is the pointer, of which only bits 2:0 count and bits 7:3 are ignored.
- R4: Each data byte raises `reg_we` for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments and wraps from 7 to 0.
- R5: Pointer values 6 and 7 are acknowledged, but no `reg_we` pulse is produced for them.
- R6: Every accepted byte (address, pointer, data) is acknowledged by pulling SDA low during the 9th SCL clock. SDA is released at all other times except read data bits.
- R7: R/W = 1 selects a read. The block samples `status_i`, pulses `reg_rd` for one cycle, and sends the byte MSB first. SDA changes only while SCL is low.
- R8: If the master ACKs a read byte, a fresh status byte is sampled (a new `reg_rd`) and sent. If the master NACKs, SDA stays released until the next START.
- R9: STOP ends a transfer, and clocking after it has no effect. A repeated START restarts address reception, followed by a new pointer phase.
- R10: A pulse on SCL or SDA shorter than three clock samples is ignored.
- R11: After reset, `sda_oe`, `reg_we` and `reg_rd` are 0.
- R12: `reg_we` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three bits of the device address |
| status_i | input | 8 | Byte returned by a read transfer |
| reg_we | output | 1 | One-cycle write strobe |
| reg_addr | output | 3 | Register pointer for the write |
| reg_wdata | output | 8 | Written byte |
| reg_rd | output | 1 | One-cycle strobe when the status byte is sampled |

## Verification
Two things happen in the same clock cycle: the decision whether a data byte is written, and the pointer increment that follows it.

The bench provokes this with a burst that starts at pointer 5 and runs through 6, 7, 0 and 1. The scoreboard expects writes only at 5, 0 and 1, each carrying the right byte. It also expects every byte of the burst, including the discarded ones, to be acknowledged.

A wrong decision shows up either as a write to 6 or 7, or as a write to 0 or 1 carrying the wrong byte.

// File: rtl/i2c_subaddr_slave.sv
module i2c_subaddr_slave #(
  parameter logic [3:0] ADDR_HI = 4'b0100,
  parameter int FILT = 3,
  parameter int NREG = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic [7:0] status_i,
  output logic       reg_we,
  output logic [2:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd
);
  localparam logic [3:0] NREG_L = 4'(NREG);

  typedef enum logic [2:0] {IDLE, RX, ACK, TX, MACK} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} ph_t;

  logic [1:0] scl_sy, sda_sy;
  logic [FILT-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[FILT-2:0], scl_sy[1]};
      sda_h  <= {sda_h[FILT-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t st;
  ph_t ph;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [2:0] sub;
  logic rw, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; ph <= PH_ADDR; bitcnt <= '0; sh <= '0; sub <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0; reg_rd <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_rd <= 1'b0;
      if (start_c) begin
        st <= RX; ph <= PH_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          RX:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (ph)
                PH_ADDR:
                  if (sh[7:1] == {ADDR_HI, strap_i}) begin
                    rw <= sh[0]; st <= ACK; sda_oe <= 1'b1;
                  end else st <= IDLE;
                PH_SUB: begin
                  sub <= sh[2:0]; st <= ACK; sda_oe <= 1'b1;
                end
                default: begin
                  if ({1'b0, sub} < NREG_L) begin
                    reg_we <= 1'b1; reg_addr <= sub; reg_wdata <= sh;
                  end
                  sub <= sub + 3'd1; st <= ACK; sda_oe <= 1'b1;
                end
              endcase
            end
          ACK:
            if (scl_fall) begin
              bitcnt <= '0;
              if (ph == PH_ADDR && rw) begin
                sh <= status_i; reg_rd <= 1'b1; st <= TX; sda_oe <= ~status_i[7];
              end else begin
                sda_oe <= 1'b0; st <= RX;
                ph <= (ph == PH_ADDR) ? PH_SUB : PH_DATA;
              end
            end
          TX:
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0; st <= MACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1; sda_oe <= ~sh[6];
              end
            end
          MACK:
            if (scl_rise) mack <= ~sda_f;
            else if (scl_fall) begin
              if (mack) begin
                sh <= status_i; reg_rd <= 1'b1; bitcnt <= '0; st <= TX;
                sda_oe <= ~status_i[7];
              end else st <= IDLE;
            end
          default: ;
        endcase
      end
    end
endmodule

module i2c_subaddr_slave_chk #(parameter int NREG = 6) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       reg_we,
  input logic       reg_rd,
  input logic [2:0] reg_addr,
  input logic       scl_f
);
  assert_we_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ({29'd0, reg_addr} < NREG));
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_rd));
  assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
endmodule

bind i2c_subaddr_slave i2c_subaddr_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .scl_f(scl_f));

// File: tb/tb_i2c_subaddr_slave.sv
module tb_i2c_subaddr_slave;
  localparam int Q = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] status = 8'h00;
  logic sda_oe, reg_we, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_subaddr_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .status_i(status), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd));

  int checks = 0, errors = 0, rd_count = 0;
  logic [10:0] expq[$];
  logic oe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start; sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q); endtask
  task automatic bus_stop; sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(Q); endtask
  task automatic bus_bit(input bit b, output bit s);
    sda_m = b; w(Q); scl_m = 1; w(Q); s = sda_bus; w(Q); scl_m = 0; w(Q);
  endtask
  task automatic send(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic recv(output logic [7:0] v, input bit mack, input logic [7:0] nxt);
    bit s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); v[i] = s; end
    status = nxt;
    bus_bit(!mack, s);
  endtask
  task automatic push(input logic [2:0] a, input logic [7:0] d); expq.push_back({a, d}); endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (reg_rd) rd_count++;
    if (reg_we) begin
      if (expq.size() == 0) chk(1'b0, "R2 R5 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [10:0] e;
        e = expq.pop_front();
        chk({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
    if (sda_oe != oe_prev) chk(!scl_m, "R7 SDA changed while SCL high", scl_m, 0);
    oe_prev <= sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack, s;
    logic [7:0] v;
    int rc0;
    w(5);
    chk({sda_oe, reg_we, reg_rd} == 3'b000, "R11 reset outputs", {sda_oe, reg_we, reg_rd}, 0);
    rst_n = 1; w(5);

    // R1 R3 R6: write, pointer byte with upper bits set
    bus_start;
    send({4'b0100, 3'b101, 1'b0}, ack); chk(ack, "R1 address ack strap 101", ack, 1);
    send(8'hF9, ack); chk(ack, "R6 pointer ack", ack, 1);
    push(3'd1, 8'h11); send(8'h11, ack); chk(ack, "R6 data ack", ack, 1);
    push(3'd2, 8'h22); send(8'h22, ack);
    push(3'd3, 8'h33); send(8'h33, ack);
    bus_stop; w(20);
    chk(expq.size() == 0, "R3 R4 burst writes done", expq.size(), 0);

    strap = 3'b010;
    bus_start;
    send(8'h44, ack); chk(ack, "R1 address ack strap 010", ack, 1);
    send(8'h00, ack);
    push(3'd0, 8'h5A); send(8'h5A, ack);
    bus_stop; w(20);

    // R2: old address no longer matches
    bus_start;
    send({4'b0100, 3'b101, 1'b0}, ack); chk(!ack, "R2 mismatch no ack", ack, 0);
    send(8'h00, ack); chk(!ack, "R2 later byte no ack", ack, 0);
    send(8'h77, ack);
    bus_stop; w(20);
    chk(expq.size() == 0, "R2 no writes", expq.size(), 0);

    // R5 wrap burst 5,6,7,0,1
    bus_start;
    send(8'h44, ack); send(8'h05, ack);
    push(3'd5, 8'hA1); send(8'hA1, ack);
    send(8'hA2, ack); chk(ack, "R5 pointer 6 acked", ack, 1);
    send(8'hA3, ack); chk(ack, "R5 pointer 7 acked", ack, 1);
    push(3'd0, 8'hA4); send(8'hA4, ack);
    push(3'd1, 8'hA5); send(8'hA5, ack);
    bus_stop; w(20);
    chk(expq.size() == 0, "R4 R5 wrap writes", expq.size(), 0);

    // R7 R8 read
    status = 8'hA6; rc0 = rd_count;
    bus_start;
    send(8'h45, ack); chk(ack, "R7 read address ack", ack, 1);
    recv(v, 1'b1, 8'h3C); chk(v == 8'hA6, "R7 status byte", v, 8'hA6);
    recv(v, 1'b0, 8'h3C); chk(v == 8'h3C, "R8 resent status after ACK", v, 8'h3C);
    bus_bit(1'b1, s); chk(s == 1'b1, "R8 SDA released after NACK", s, 1);
    bus_stop; w(20);
    chk(rd_count - rc0 == 2, "R8 read strobes", rd_count - rc0, 2);

    // R9 repeated start and post-stop clocking
    bus_start;
    send(8'h44, ack); send(8'h02, ack);
    push(3'd2, 8'hC2); send(8'hC2, ack);
    bus_start;
    send(8'h44, ack); chk(ack, "R9 address after repeated START", ack, 1);
    send(8'h04, ack);
    push(3'd4, 8'hD4); send(8'hD4, ack);
    bus_stop; w(20);
    send(8'h55, ack); chk(!ack, "R9 no ack after STOP", ack, 0);
    w(20);
    chk(expq.size() == 0, "R9 writes", expq.size(), 0);

    // R10 short SCL glitch inside a data byte
    bus_start;
    send(8'h44, ack); send(8'h03, ack);
    push(3'd3, 8'h96);
    for (int i = 7; i >= 0; i--) begin
      bus_bit(v[0] | 1'b1 ? 8'h96 >> i : 1'b0, s);
      if (i == 4) begin scl_m = 1; w(2); scl_m = 0; w(Q); end
    end
    bus_bit(1'b1, s); chk(!s, "R10 ack after glitched byte", !s, 1);
    bus_stop; w(20);
    chk(expq.size() == 0, "R10 glitched byte written intact", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule